// File: doc/BRIEF.md
# Qword Payload Aligner

This block takes the payload of one packet at a time as a stream of 32-bit dwords and re-packs it into a 64-bit stream. Each output beat starts on a qword boundary, and each beat carries an 8-bit byte-enable vector. With the first dword of a packet the caller also presents a small descriptor: the packet kind, bit 2 of the request address, bit 2 of the completion lower-address field, the payload length in dwords, and the enable nibbles for the first and last dwords. The block reads the kind and the matching address bit and decides whether the payload starts in the low half or the high half of the first beat. It then fills beats two dwords at a time, and the final beat may be half empty. Alignment is always on and has no bypass.

The input side uses valid/ready with a ready latency of two cycles. The upstream may drive a dword in cycle c only if `in_ready` was high in cycle c-2. After `in_ready` falls, up to two more dwords can still arrive, and a small internal queue takes them. The output side uses plain valid/ready with no latency. A beat transfers on a clock edge where `out_valid` and `out_ready` are both high. While `out_ready` is low, the offered beat and its flags hold steady. Back-pressure from the output backs up through the queue to `in_ready`.

Top module: `qword_payload_aligner`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `out_valid` is 0 and `in_ready` is 1.
- R2: Kind 0 (request with data): when the request address bit 2 is 1, the first payload dword goes in bits 63:32 of the first beat, and bits 31:0 carry zero data with zero enables. When that bit is 0, the first dword goes in bits 31:0.
- R3: Kind 1 (completion with data): the start offset comes from bit 2 of the lower-address field, and the request address bit has no effect.
- R4: Kind 2 (completion for a configuration or I/O read): the payload always starts in bits 31:0, whatever either address bit says.
- R5: Byte-enable bit i qualifies byte lane i of `out_data` (bits 8i+7:8i). The first dword takes the first-dword nibble, the last dword takes the last-dword nibble, and every dword between them is fully enabled (4'hF).
- R6: When the length is 1, the dword's enables come only from the first-dword nibble, and the last-dword nibble has no effect.
- R7: A packet of length L with start offset o gives ceil((L+o)/2) beats. `out_sop` marks the first of them and `out_eop` the last. When the final beat holds one dword, its other half carries zero data and zero enables.
- R8: While `out_valid` is 1 and `out_ready` is 0, the next cycle keeps `out_valid`, `out_data`, `out_be`, `out_sop` and `out_eop` unchanged.
- R9: `in_ready` falls once the queue can no longer take two in-flight dwords. Every dword sent under the two-cycle rule is delivered, with nothing lost or duplicated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input dword present |
| in_ready | output | 1 | Upstream may send two cycles later |
| in_sop | input | 1 | Dword is the first of its packet; descriptor valid |
| in_data | input | 32 | Payload dword |
| desc_kind | input | 2 | 0 request with data, 1 completion with data, 2 config/I-O read completion, 3 treated as aligned |
| desc_req_a2 | input | 1 | Bit 2 of the request address |
| desc_cpl_a2 | input | 1 | Bit 2 of the completion lower-address field |
| desc_len | input | 10 | Payload length in dwords, 1 to 1023 |
| desc_first_be | input | 4 | Enables of the first payload dword |
| desc_last_be | input | 4 | Enables of the last payload dword |
| out_valid | output | 1 | Output beat present |
| out_ready | input | 1 | Downstream takes the beat |
| out_data | output | 64 | Qword-aligned payload beat |
| out_be | output | 8 | Per-byte enables of the beat |
| out_sop | output | 1 | First beat of a packet |
| out_eop | output | 1 | Last beat of a packet |

## Verification
The bench targets odd start offsets combined with odd and even lengths, single-dword packets with a conflicting last nibble, and completions whose two address bits disagree. A design that picks the wrong address bit, or shifts a config read completion, puts every dword in the wrong half. Mixing up the nibbles gives wrong enables at the edges of the packet. Losing the half-beat case drops or duplicates a dword at the end of the packet. Stall patterns on the output check that a held beat does not change. A long output stall fills the queue, and any dword dropped while `in_ready` falls shows up as a missing beat.

// File: rtl/qa_pkg.sv
package qa_pkg;
  localparam int DW_W  = 32;
  localparam int QW_W  = 2 * DW_W;
  localparam int NIB_W = DW_W / 8;
  localparam int BE_W  = QW_W / 8;
  localparam int LEN_W = 10;

  typedef enum logic [1:0] {
    PK_REQ_WR    = 2'd0,
    PK_CPL_DATA  = 2'd1,
    PK_CPL_CFGIO = 2'd2,
    PK_RSVD      = 2'd3
  } pkt_kind_e;

  typedef struct packed {
    logic             sop;
    logic             offs;
    logic [LEN_W-1:0] len;
    logic [NIB_W-1:0] fbe;
    logic [NIB_W-1:0] lbe;
    logic [DW_W-1:0]  data;
  } qa_entry_t;

  // picks the address bit that decides the start half of the first beat
  function automatic logic lead_offset(pkt_kind_e k, logic req_b2, logic cpl_b2);
    logic r;
    unique case (k)
      PK_REQ_WR:   r = req_b2;
      PK_CPL_DATA: r = cpl_b2;
      default:     r = 1'b0;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/qa_skid_fifo.sv
module qa_skid_fifo
  import qa_pkg::*;
#(
  parameter int DEPTH     = 8,
  parameter int READY_LAT = 2
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      wr_en,
  input  qa_entry_t wr_ent,
  output logic      wr_ready,
  output logic      rd_avail,
  output qa_entry_t rd_ent,
  input  logic      rd_en
);
  localparam int PTR_W     = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W     = $clog2(DEPTH + 1);
  localparam int HIGH_MARK = DEPTH - 1 - READY_LAT;

  qa_entry_t        mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] count;
  logic             do_rd;

  function automatic logic [PTR_W-1:0] bump(logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  assign do_rd    = rd_en && (count != '0);
  assign rd_avail = (count != '0);
  assign rd_ent   = mem[rd_ptr];
  // room must cover every dword already launched under the ready latency
  assign wr_ready = (count <= CNT_W'(HIGH_MARK));

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_ptr] <= wr_ent;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (wr_en) wr_ptr <= bump(wr_ptr);
      if (do_rd) rd_ptr <= bump(rd_ptr);
      case ({wr_en, do_rd})
        2'b10:   count <= count + CNT_W'(1);
        2'b01:   count <= count - CNT_W'(1);
        default: count <= count;
      endcase
    end
  end

  // R9
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (count < CNT_W'(DEPTH)));
endmodule

// File: rtl/qa_beat_packer.sv
module qa_beat_packer
  import qa_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  qa_entry_t        ent,
  input  logic             ent_avail,
  output logic             ent_pop,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [QW_W-1:0]  out_data,
  output logic [BE_W-1:0]  out_be,
  output logic             out_sop,
  output logic             out_eop
);
  logic             have_lo, lo_sop;
  logic [DW_W-1:0]  lo_data;
  logic [NIB_W-1:0] lo_be, lbe_q;
  logic [LEN_W-1:0] rem_q;

  logic [LEN_W-1:0] cur_rem;
  logic [NIB_W-1:0] cur_lbe, dw_be;
  logic             is_last, completes, slot_free;
  logic [QW_W-1:0]  nx_data;
  logic [BE_W-1:0]  nx_be;
  logic             nx_sop;

  always_comb begin
    cur_rem   = ent.sop ? ent.len : rem_q;
    cur_lbe   = ent.sop ? ent.lbe : lbe_q;
    is_last   = (cur_rem == LEN_W'(1));
    // first nibble wins, which also covers the one-dword packet
    dw_be     = ent.sop ? ent.fbe : (is_last ? cur_lbe : {NIB_W{1'b1}});
    completes = (ent.sop && ent.offs) || have_lo || is_last;
    slot_free = !out_valid || out_ready;
    ent_pop   = ent_avail && (!completes || slot_free);

    if (ent.sop && ent.offs) begin
      nx_data = {ent.data, {DW_W{1'b0}}};
      nx_be   = {dw_be, {NIB_W{1'b0}}};
      nx_sop  = 1'b1;
    end else if (have_lo) begin
      nx_data = {ent.data, lo_data};
      nx_be   = {dw_be, lo_be};
      nx_sop  = lo_sop;
    end else begin
      nx_data = {{DW_W{1'b0}}, ent.data};
      nx_be   = {{NIB_W{1'b0}}, dw_be};
      nx_sop  = ent.sop;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      have_lo <= 1'b0;
      lo_sop  <= 1'b0;
      lo_data <= '0;
      lo_be   <= '0;
      lbe_q   <= '0;
      rem_q   <= '0;
    end else if (ent_pop) begin
      rem_q <= cur_rem - LEN_W'(1);
      if (ent.sop) lbe_q <= ent.lbe;
      have_lo <= !completes;
      if (!completes) begin
        lo_data <= ent.data;
        lo_be   <= dw_be;
        lo_sop  <= ent.sop;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_be    <= '0;
      out_sop   <= 1'b0;
      out_eop   <= 1'b0;
    end else if (slot_free) begin
      out_valid <= ent_pop && completes;
      if (ent_pop && completes) begin
        out_data <= nx_data;
        out_be   <= nx_be;
        out_sop  <= nx_sop;
        out_eop  <= is_last;
      end
    end
  end

  // R8
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_be)
      && $stable(out_sop) && $stable(out_eop));
  // R5
  interior_full_be_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_sop && !out_eop |-> out_be == {BE_W{1'b1}});
  // R7
  eop_then_sop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && out_eop |=> !out_valid || out_sop);
  // R7
  mid_no_sop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && !out_eop |=> !out_valid || !out_sop);
endmodule

// File: rtl/qword_payload_aligner.sv
module qword_payload_aligner
  import qa_pkg::*;
#(
  parameter int FIFO_DEPTH = 8,
  parameter int READY_LAT  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic             in_sop,
  input  logic [DW_W-1:0]  in_data,
  input  logic [1:0]       desc_kind,
  input  logic             desc_req_a2,
  input  logic             desc_cpl_a2,
  input  logic [LEN_W-1:0] desc_len,
  input  logic [NIB_W-1:0] desc_first_be,
  input  logic [NIB_W-1:0] desc_last_be,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [QW_W-1:0]  out_data,
  output logic [BE_W-1:0]  out_be,
  output logic             out_sop,
  output logic             out_eop
);
  qa_entry_t wr_ent, rd_ent;
  logic      rd_avail, rd_en;

  always_comb begin
    wr_ent.sop  = in_sop;
    wr_ent.offs = lead_offset(pkt_kind_e'(desc_kind), desc_req_a2, desc_cpl_a2);
    wr_ent.len  = desc_len;
    wr_ent.fbe  = desc_first_be;
    wr_ent.lbe  = desc_last_be;
    wr_ent.data = in_data;
  end

  qa_skid_fifo #(.DEPTH(FIFO_DEPTH), .READY_LAT(READY_LAT)) u_fifo (
    .clk(clk), .rst_n(rst_n),
    .wr_en(in_valid), .wr_ent(wr_ent), .wr_ready(in_ready),
    .rd_avail(rd_avail), .rd_ent(rd_ent), .rd_en(rd_en)
  );

  qa_beat_packer u_pack (
    .clk(clk), .rst_n(rst_n),
    .ent(rd_ent), .ent_avail(rd_avail), .ent_pop(rd_en),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_be(out_be),
    .out_sop(out_sop), .out_eop(out_eop)
  );
endmodule

// File: tb/qword_payload_aligner_test.sv
`timescale 1ns/1ps
module qword_payload_aligner_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, in_sop = 1'b0, out_ready = 1'b0;
  logic in_ready, out_valid, out_sop, out_eop;
  logic [31:0] in_data = '0;
  logic [1:0]  desc_kind = '0;
  logic        desc_req_a2 = 1'b0, desc_cpl_a2 = 1'b0;
  logic [9:0]  desc_len = '0;
  logic [3:0]  desc_first_be = '0, desc_last_be = '0;
  logic [63:0] out_data;
  logic [7:0]  out_be;

  always #5 clk = ~clk;

  qword_payload_aligner uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_sop(in_sop), .in_data(in_data), .desc_kind(desc_kind),
    .desc_req_a2(desc_req_a2), .desc_cpl_a2(desc_cpl_a2), .desc_len(desc_len),
    .desc_first_be(desc_first_be), .desc_last_be(desc_last_be),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_be(out_be), .out_sop(out_sop), .out_eop(out_eop)
  );

  // {kind 2, addr 8, lower addr 8, len 10, first nibble 4, last nibble 4}
  localparam int NV = 10;
  localparam logic [35:0] VEC [0:NV-1] = '{
    {2'd0, 8'h00, 8'h00, 10'd4, 4'hF, 4'hF},
    {2'd0, 8'h04, 8'h00, 10'd3, 4'hE, 4'h3},
    {2'd0, 8'h0C, 8'h00, 10'd1, 4'h6, 4'hA},
    {2'd0, 8'h08, 8'h04, 10'd1, 4'h9, 4'hF},
    {2'd1, 8'h00, 8'h04, 10'd2, 4'hF, 4'h1},
    {2'd1, 8'h04, 8'h00, 10'd5, 4'h8, 4'h7},
    {2'd2, 8'h04, 8'h04, 10'd1, 4'hF, 4'hF},
    {2'd2, 8'h0C, 8'h44, 10'd2, 4'hF, 4'hF},
    {2'd0, 8'h24, 8'h00, 10'd6, 4'hC, 4'h1},
    {2'd1, 8'h00, 8'h7C, 10'd2, 4'h1, 4'h8}
  };

  int tests = 0, fails = 0, cyc = 0;
  logic [1:0] hist = '0;
  logic hold_out = 1'b0, stall_pat = 1'b0;
  logic [63:0] q_data[$];
  logic [7:0]  q_be[$];
  logic        q_sop[$], q_eop[$];
  string       q_dtag[$], q_btag[$];
  logic        prev_stall = 1'b0;
  logic [63:0] prev_data = '0;
  logic [7:0]  prev_be = '0;

  always @(posedge clk) begin
    hist <= {hist[0], in_ready};
    cyc  <= cyc + 1;
  end

  task automatic chk(input logic ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    if (cyc > 100000) begin
      tests++; fails++;
      $display("FAIL watchdog: actual %0d expected below 100000 cycles", cyc);
      finish_run();
    end
  end

  function automatic logic [31:0] pat(input int tag, input int j);
    return {8'(tag), 8'hC3, 16'(j)};
  endfunction

  function automatic logic [3:0] dwbe(input int j, input int len, input logic [3:0] fb, input logic [3:0] lb);
    if (j == 0) return fb;
    if (j == len - 1) return lb;
    return 4'hF;
  endfunction

  // output side: drive ready, then compare whatever transfers at the next edge
  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_stall) begin
        chk(out_valid && out_data == prev_data && out_be == prev_be, "R8", "held beat",
            {out_data[62:0], out_valid}, {prev_data[62:0], 1'b1});
      end
      out_ready = !hold_out && (!stall_pat || (cyc % 3 != 0));
      if (out_valid && out_ready) begin
        if (q_data.size() == 0) begin
          chk(1'b0, "R9", "unexpected beat", out_data, 64'h0);
        end else begin
          chk(out_data == q_data[0], q_dtag[0], "data", out_data, q_data[0]);
          chk(out_be == q_be[0], q_btag[0], "byte enables", 64'(out_be), 64'(q_be[0]));
          chk(out_sop == q_sop[0] && out_eop == q_eop[0], "R7", "sop/eop",
              64'({out_sop, out_eop}), 64'({q_sop[0], q_eop[0]}));
          void'(q_data.pop_front()); void'(q_be.pop_front());
          void'(q_sop.pop_front());  void'(q_eop.pop_front());
          void'(q_dtag.pop_front()); void'(q_btag.pop_front());
        end
      end
      prev_stall = out_valid && !out_ready;
      prev_data  = out_data;
      prev_be    = out_be;
    end
  end

  task automatic send_pkt(input logic [1:0] k, input logic a2, input logic c2, input int len,
                          input logic [3:0] fb, input logic [3:0] lb, input int tag);
    int off;
    int nb;
    off = (k == 2'd0) ? int'(a2) : (k == 2'd1) ? int'(c2) : 0;
    nb  = (len + off + 1) / 2;
    for (int b = 0; b < nb; b++) begin
      logic [63:0] d;
      logic [7:0]  e;
      d = '0; e = '0;
      for (int h = 0; h < 2; h++) begin
        int j;
        j = 2 * b + h - off;
        if (j >= 0 && j < len) begin
          d[32*h +: 32] = pat(tag, j);
          e[4*h +: 4]   = dwbe(j, len, fb, lb);
        end
      end
      q_data.push_back(d); q_be.push_back(e);
      q_sop.push_back(b == 0); q_eop.push_back(b == nb - 1);
      q_dtag.push_back(k == 2'd0 ? "R2" : (k == 2'd1 ? "R3" : "R4"));
      q_btag.push_back(len == 1 ? "R6" : "R5");
    end
    for (int j = 0; j < len; j++) begin
      @(negedge clk);
      while (!hist[1]) begin
        in_valid = 1'b0;
        @(negedge clk);
      end
      in_valid = 1'b1; in_sop = (j == 0); in_data = pat(tag, j);
      desc_kind = k; desc_req_a2 = a2; desc_cpl_a2 = c2; desc_len = 10'(len);
      desc_first_be = fb; desc_last_be = lb;
    end
  endtask

  task automatic drain();
    @(negedge clk);
    in_valid = 1'b0;
    while (q_data.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    chk(!out_valid && in_ready, "R1", "during reset", 64'({out_valid, in_ready}), 64'b01);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!out_valid && in_ready, "R1", "after reset", 64'({out_valid, in_ready}), 64'b01);

    // table walk: once with a free output, once with a stall pattern (R8)
    for (int pass = 0; pass < 2; pass++) begin
      stall_pat = (pass == 1);
      for (int v = 0; v < NV; v++) begin
        logic [35:0] x;
        x = VEC[v];
        send_pkt(x[35:34], x[28], x[20], int'(x[17:8]), x[7:4], x[3:0], pass * 16 + v);
      end
      drain();
    end

    // R9: hold the output until the queue backs up, then release
    stall_pat = 1'b0;
    hold_out  = 1'b1;
    fork
      send_pkt(2'd0, 1'b1, 1'b0, 20, 4'h7, 4'hE, 40);
      begin
        repeat (40) @(negedge clk);
        chk(!in_ready, "R9", "ready low under stall", 64'(in_ready), 64'h0);
        hold_out = 1'b0;
      end
    join
    drain();

    // R6 and R4 with back-to-back odd shapes
    send_pkt(2'd1, 1'b1, 1'b1, 1, 4'h2, 4'h0, 50);
    send_pkt(2'd2, 1'b1, 1'b1, 3, 4'h1, 4'h8, 51);
    send_pkt(2'd0, 1'b1, 1'b1, 2, 4'hF, 4'h3, 52);
    drain();

    chk(q_data.size() == 0, "R9", "all beats delivered", 64'(q_data.size()), 64'h0);
    finish_run();
  end
endmodule